// File: doc/BRIEF.md
# Atomic Message Network Interface

This block sits between a processor and a packet network. Software builds an outbound message one word at a time in a small bank of staging registers, then issues a launch command together with the message length. No flit leaves the block before that command. After it, the whole message streams out on a valid/ready port, and the final flit is flagged as the tail. Because construction is separate from injection, an operating system can read the staging bank back and rewrite it across a context switch, and the network never sees a partial message.

On the inbound side, complete messages collect in a word queue. The message at the head of the queue is exposed through an indexed read window along with its length. A presence flag supports polling. An interrupt is raised only while the interrupt enable is set, so a handler or a polling loop can run without interruption. A dispose command frees the head message and brings the next one forward. Misused commands set two sticky error flags: a staging write or launch during a drain, and a dispose with nothing queued.

Top module: `atomic_msg_nif`

## Requirements
- R1: A staging write at index i stores the word, and the word reads back unchanged at `stg_rd_data` while idle, so software can save and restore the bank.
- R2: `tx_valid` stays low until a launch. A launch with `launch_len_m1 = L` while idle emits exactly L+1 flits, carrying staging words 0..L in order. Flits start the cycle after the launch edge.
- R3: `tx_tail` is high on the last flit of a message and low on every other flit. While `tx_valid` is high and `tx_ready` is low, the flit holds its data and tail.
- R4: While a message is draining (`tx_busy` = 1), staging writes and launches are ignored and set the sticky `stg_err`. The staged words and the outgoing stream are left unaltered.
- R5: `rx_present` rises the cycle after the tail word of an inbound message is accepted. `rx_len_m1` then gives the head length minus one, and `rx_rd_data` at index j returns word j of the head message, or 0 when j is beyond the length.
- R6: A dispose while a message is present removes the head message. The next queued message, or an empty state, is visible the following cycle.
- R7: A dispose when no message is present sets the sticky `disp_err` and leaves the queue unchanged.
- R8: `rx_ready` is low whenever the word store (RXQ_WORDS) or the message count (RXQ_MSGS) is full.
- R9: `irq` is registered. It is high one cycle after both a message is present and the enable is set, and low one cycle after either is cleared. `rx_present` ignores the enable.
- R10: `err_clr` clears both sticky error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_wr_en | input | 1 | Staging word write strobe |
| stg_wr_idx | input | IDX_W | Staging write index |
| stg_wr_data | input | DATA_W | Staging write word |
| stg_rd_idx | input | IDX_W | Staging read-back index |
| stg_rd_data | output | DATA_W | Staging read-back word |
| launch | input | 1 | Atomic launch command |
| launch_len_m1 | input | IDX_W | Message length minus one |
| tx_busy | output | 1 | Message draining |
| stg_err | output | 1 | Sticky: write or launch while draining |
| tx_valid | output | 1 | Outbound flit valid |
| tx_ready | input | 1 | Outbound flit accepted |
| tx_data | output | DATA_W | Outbound flit |
| tx_tail | output | 1 | Last flit of message |
| rx_valid | input | 1 | Inbound word valid |
| rx_ready | output | 1 | Inbound word accepted |
| rx_data | input | DATA_W | Inbound word |
| rx_tail | input | 1 | Inbound word ends a message |
| rx_present | output | 1 | Poll flag: a message is queued |
| rx_len_m1 | output | IDX_W | Head message length minus one |
| rx_rd_idx | input | IDX_W | Head message read index |
| rx_rd_data | output | DATA_W | Head message word |
| dispose | input | 1 | Free the head message |
| disp_err | output | 1 | Sticky: dispose with nothing queued |
| irq_en_we | input | 1 | Interrupt enable write strobe |
| irq_en_wdata | input | 1 | New interrupt enable value |
| irq | output | 1 | Message interrupt |
| err_clr | input | 1 | Clear both sticky errors |

## Verification
Staging read-back and the head-message window are combinational over registers, so they are sampled just after the edge that wrote them. Flits appear one edge after launch and advance on each edge where valid and ready are both high. The bench records each flit just before the edge that takes it, sweeping every length with both a steady and a toggling `tx_ready`. `rx_present`, the head fields and the error flags change one edge after the tail word, dispose or offending command. `irq` follows one further edge later, and the bench waits that extra cycle before every interrupt check.

// File: rtl/nif_pkg.sv
package nif_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_DRAIN = 1'b1} tx_state_e;

  // Number of words in a message whose length-minus-one field is len_m1.
  function automatic int unsigned words_of(input int unsigned len_m1);
    return len_m1 + 1;
  endfunction
endpackage

// File: rtl/nif_tx_stage.sv
module nif_tx_stage
  import nif_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 4,
  parameter int IDX_W     = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              launch,
  input  logic [IDX_W-1:0]  len_m1,
  input  logic              err_clr,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_tail,
  output logic              busy,
  output logic              err
);
  logic [DATA_W-1:0] stg_q [MAX_WORDS];
  tx_state_e         st_q;
  logic [IDX_W-1:0]  len_q, pos_q;
  logic              err_q;

  // Named events for the assertions.
  logic flit_go, launch_ok, wr_blocked, launch_blocked, last_flit;
  assign busy           = (st_q == TX_DRAIN);
  assign flit_go        = tx_valid && tx_ready;
  assign launch_ok      = launch && !busy;
  assign wr_blocked     = wr_en && busy;
  assign launch_blocked = launch && busy;
  assign last_flit      = (pos_q == len_q);

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)                                        stg_q[g] <= '0;
      else if (wr_en && !busy && wr_idx == IDX_W'(g))    stg_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      len_q <= '0;
      pos_q <= '0;
    end else if (launch_ok) begin
      st_q  <= TX_DRAIN;
      len_q <= len_m1;
      pos_q <= '0;
    end else if (flit_go) begin
      if (last_flit) st_q <= TX_IDLE;
      else           pos_q <= pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           err_q <= 1'b0;
    else if (wr_blocked || launch_blocked) err_q <= 1'b1;
    else if (err_clr)                      err_q <= 1'b0;
  end

  assign err      = err_q;
  assign rd_data  = stg_q[rd_idx];
  assign tx_valid = busy;
  assign tx_data  = stg_q[pos_q];
  assign tx_tail  = busy && last_flit;

  AST_FLIT_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(launch)); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_tail)); // R3
  AST_TAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_tail |=> !tx_valid || $past(launch)); // R3
  AST_BUSY_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> err && $stable(tx_data)); // R4
endmodule

// File: rtl/nif_rx_queue.sv
module nif_rx_queue #(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 4,
  parameter int RXQ_WORDS = 8,
  parameter int RXQ_MSGS  = 4,
  parameter int IDX_W     = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_tail,
  output logic              present,
  output logic [IDX_W-1:0]  head_len_m1,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dispose,
  input  logic              err_clr,
  output logic              err
);
  localparam int QP_W = $clog2(RXQ_WORDS);
  localparam int QC_W = QP_W + 1;
  localparam int MP_W = $clog2(RXQ_MSGS);
  localparam int MC_W = MP_W + 1;

  logic [DATA_W-1:0] mem_q  [RXQ_WORDS];
  logic [IDX_W-1:0]  lenq_q [RXQ_MSGS];
  logic [QP_W-1:0]   wr_ptr_q, head_ptr_q;
  logic [QC_W-1:0]   wcnt_q;
  logic [MP_W-1:0]   mwr_q, mrd_q;
  logic [MC_W-1:0]   mcnt_q;
  logic [IDX_W-1:0]  build_q;
  logic              err_q;

  // Ring pointer advance by n words.
  function automatic logic [QP_W-1:0] ring_add(input logic [QP_W-1:0] p,
                                               input logic [QC_W-1:0] n);
    logic [QC_W-1:0] s;
    s = {1'b0, p} + n;
    return s[QP_W-1:0];
  endfunction

  // Words held by a message with the given length field.
  function automatic logic [QC_W-1:0] msg_words(input logic [IDX_W-1:0] l);
    return QC_W'(l) + 1'b1;
  endfunction

  logic accept, push_msg, pop_msg, empty_dispose;
  logic [QC_W-1:0] pop_words;
  assign in_ready      = (wcnt_q < QC_W'(RXQ_WORDS)) && (mcnt_q < MC_W'(RXQ_MSGS));
  assign accept        = in_valid && in_ready;
  assign push_msg      = accept && in_tail;
  assign present       = (mcnt_q != '0);
  assign pop_msg       = dispose && present;
  assign empty_dispose = dispose && !present;
  assign head_len_m1   = present ? lenq_q[mrd_q] : '0;
  assign pop_words     = pop_msg ? msg_words(lenq_q[mrd_q]) : '0;

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_ptr_q] <= in_data;
    if (push_msg) lenq_q[mwr_q] <= build_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q   <= '0;
      head_ptr_q <= '0;
      wcnt_q     <= '0;
      mwr_q      <= '0;
      mrd_q      <= '0;
      mcnt_q     <= '0;
      build_q    <= '0;
    end else begin
      if (accept) begin
        wr_ptr_q <= ring_add(wr_ptr_q, QC_W'(1));
        build_q  <= in_tail ? '0 : build_q + 1'b1;
      end
      if (push_msg) mwr_q <= mwr_q + 1'b1;
      if (pop_msg) begin
        head_ptr_q <= ring_add(head_ptr_q, pop_words);
        mrd_q      <= mrd_q + 1'b1;
      end
      wcnt_q <= wcnt_q + QC_W'(accept) - pop_words;
      mcnt_q <= mcnt_q + MC_W'(push_msg) - MC_W'(pop_msg);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             err_q <= 1'b0;
    else if (empty_dispose) err_q <= 1'b1;
    else if (err_clr)       err_q <= 1'b0;
  end
  assign err = err_q;

  always_comb begin
    rd_data = '0;
    if (present && rd_idx <= lenq_q[mrd_q])
      rd_data = mem_q[ring_add(head_ptr_q, QC_W'(rd_idx))];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= QC_W'(RXQ_WORDS) && mcnt_q <= MC_W'(RXQ_MSGS)); // R8
  AST_TAIL_MAKES_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    push_msg |=> present); // R5
  AST_EMPTY_DISPOSE: assert property (@(posedge clk) disable iff (!rst_n)
    empty_dispose && !push_msg |=> err && !present); // R7
  AST_DISPOSE_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_msg && !push_msg |=> mcnt_q == $past(mcnt_q) - 1'b1); // R6
endmodule

// File: rtl/nif_irq_ctrl.sv
module nif_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  input  logic en_we,
  input  logic en_wdata,
  output logic irq
);
  logic en_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wdata;
      irq_q <= present && en_q;
    end
  end
  assign irq = irq_q;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq); // R9
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> !irq); // R9
endmodule

// File: rtl/atomic_msg_nif.sv
module atomic_msg_nif #(
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 4,
  parameter int RXQ_WORDS = 8,
  parameter int RXQ_MSGS  = 4,
  parameter int IDX_W     = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_wr_en,
  input  logic [IDX_W-1:0]  stg_wr_idx,
  input  logic [DATA_W-1:0] stg_wr_data,
  input  logic [IDX_W-1:0]  stg_rd_idx,
  output logic [DATA_W-1:0] stg_rd_data,
  input  logic              launch,
  input  logic [IDX_W-1:0]  launch_len_m1,
  output logic              tx_busy,
  output logic              stg_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_tail,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_tail,
  output logic              rx_present,
  output logic [IDX_W-1:0]  rx_len_m1,
  input  logic [IDX_W-1:0]  rx_rd_idx,
  output logic [DATA_W-1:0] rx_rd_data,
  input  logic              dispose,
  output logic              disp_err,
  input  logic              irq_en_we,
  input  logic              irq_en_wdata,
  output logic              irq,
  input  logic              err_clr
);
  nif_tx_stage #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(stg_wr_en), .wr_idx(stg_wr_idx), .wr_data(stg_wr_data),
    .rd_idx(stg_rd_idx), .rd_data(stg_rd_data),
    .launch(launch), .len_m1(launch_len_m1), .err_clr(err_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_tail(tx_tail),
    .busy(tx_busy), .err(stg_err)
  );

  nif_rx_queue #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .RXQ_WORDS(RXQ_WORDS),
                 .RXQ_MSGS(RXQ_MSGS), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_ready(rx_ready), .in_data(rx_data), .in_tail(rx_tail),
    .present(rx_present), .head_len_m1(rx_len_m1),
    .rd_idx(rx_rd_idx), .rd_data(rx_rd_data),
    .dispose(dispose), .err_clr(err_clr), .err(disp_err)
  );

  nif_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .present(rx_present),
    .en_we(irq_en_we), .en_wdata(irq_en_wdata), .irq(irq)
  );

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !stg_wr_en && !launch && !dispose |=> !stg_err && !disp_err); // R10
endmodule

// File: tb/atomic_msg_nif_bench.sv
module atomic_msg_nif_bench;
  localparam int DW = 16, MW = 4, IW = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic stg_wr_en = 0, launch = 0, tx_ready = 0, rx_valid = 0, rx_tail = 0;
  logic dispose = 0, irq_en_we = 0, irq_en_wdata = 0, err_clr = 0;
  logic [IW-1:0] stg_wr_idx = 0, stg_rd_idx = 0, launch_len_m1 = 0, rx_rd_idx = 0;
  logic [DW-1:0] stg_wr_data = 0, rx_data = 0;
  logic [DW-1:0] stg_rd_data, tx_data, rx_rd_data;
  logic [IW-1:0] rx_len_m1;
  logic tx_busy, stg_err, tx_valid, tx_tail, rx_ready, rx_present, disp_err, irq;

  atomic_msg_nif u_atomic_msg_nif (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic stage(input int i, input logic [DW-1:0] d);
    stg_wr_en = 1; stg_wr_idx = IW'(i); stg_wr_data = d; step(); stg_wr_en = 0;
  endtask

  function automatic logic [DW-1:0] txw(input int l, input int i);
    return DW'(16'hA000 + l * 16 + i);
  endfunction

  // Collect L+1 flits; mode 1 toggles tx_ready.
  task automatic drain(input int l, input int mode, input logic [DW-1:0] exp0);
    int n = 0;
    for (int c = 0; c < 40 && n <= l; c++) begin
      tx_ready = (mode == 0) ? 1'b1 : c[0];
      #1;
      if (tx_valid && tx_ready) begin
        chk("R2 flit data", tx_data, (n == 0 && exp0 != 0) ? exp0 : txw(l, n));
        chk("R3 tail flag", tx_tail, (n == l));
        n++;
      end else if (tx_valid) begin
        chk("R3 stall tail", tx_tail, (n == l));
      end
      step();
    end
    tx_ready = 0;
    chk("R2 flit count", n, l + 1);
    chk("R2 valid drops", tx_valid, 0);
  endtask

  function automatic logic [DW-1:0] rxw(input int k, input int i);
    return DW'(16'hB000 + k * 16 + i);
  endfunction

  task automatic rx_send(input int k, input int words);
    for (int i = 0; i < words; i++) begin
      rx_valid = 1; rx_data = rxw(k, i); rx_tail = (i == words - 1);
      for (int w = 0; w < 50 && !rx_ready; w++) step();
      step();
    end
    rx_valid = 0; rx_tail = 0;
  endtask

  task automatic check_head(input int k, input int words);
    chk("R5 present", rx_present, 1);
    chk("R5 length", rx_len_m1, words - 1);
    for (int j = 0; j < MW; j++) begin
      rx_rd_idx = IW'(j); #1;
      chk("R5 head word", rx_rd_data, (j < words) ? rxw(k, j) : 0);
    end
  endtask

  task automatic do_dispose();
    dispose = 1; step(); dispose = 0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // Reset state
    chk("R2 reset valid", tx_valid, 0);
    chk("R5 reset present", rx_present, 0);
    chk("R9 reset irq", irq, 0);
    chk("R4 reset err", stg_err, 0);
    chk("R8 reset ready", rx_ready, 1);

    // R1 save/restore of staging words
    for (int i = 0; i < MW; i++) stage(i, DW'(16'h5A00 + i * 3));
    for (int i = 0; i < MW; i++) begin
      stg_rd_idx = IW'(i); #1;
      chk("R1 readback", stg_rd_data, DW'(16'h5A00 + i * 3));
    end

    // R2/R3 sweep over every length and ready pattern
    for (int mode = 0; mode < 2; mode++)
      for (int l = 0; l < MW; l++) begin
        for (int i = 0; i < MW; i++) stage(i, txw(l, i));
        step();
        chk("R2 no flit before launch", tx_valid, 0);
        launch = 1; launch_len_m1 = IW'(l); step(); launch = 0;
        drain(l, mode, 0);
      end

    // R4 writes and launches during drain
    for (int i = 0; i < MW; i++) stage(i, txw(3, i));
    launch = 1; launch_len_m1 = 3; step(); launch = 0;
    chk("R4 busy", tx_busy, 1);
    stage(0, 16'hDEAD);
    chk("R4 err set by write", stg_err, 1);
    stg_rd_idx = 0; #1;
    chk("R4 word kept", stg_rd_data, txw(3, 0));
    launch = 1; launch_len_m1 = 0; step(); launch = 0;
    chk("R4 still busy", tx_busy, 1);
    drain(3, 0, 0);
    // R10 error clear
    err_clr = 1; step(); err_clr = 0;
    chk("R10 stg_err cleared", stg_err, 0);

    // R5/R6/R9 single messages of every length
    for (int k = 1; k <= MW; k++) begin
      chk("R5 empty before", rx_present, 0);
      rx_send(k, k);
      check_head(k, k);
      step();
      chk("R9 irq masked", irq, 0);
      do_dispose();
      chk("R6 empty after", rx_present, 0);
    end

    // R9 interrupt with enable
    irq_en_we = 1; irq_en_wdata = 1; step(); irq_en_we = 0;
    rx_send(7, 2);
    chk("R9 irq not yet", irq, 0);
    step();
    chk("R9 irq raised", irq, 1);
    irq_en_we = 1; irq_en_wdata = 0; step(); irq_en_we = 0;
    chk("R9 poll ignores enable", rx_present, 1);
    step();
    chk("R9 irq masked off", irq, 0);
    irq_en_we = 1; irq_en_wdata = 1; step(); irq_en_we = 0;
    step();
    chk("R9 irq back", irq, 1);
    do_dispose();
    step();
    chk("R9 irq drops when empty", irq, 0);

    // R8 word store full, R6 ordering
    rx_send(1, 4); rx_send(2, 4);
    chk("R8 words full", rx_ready, 0);
    rx_valid = 1; rx_data = 16'hFFFF; rx_tail = 1; step(); step(); rx_valid = 0; rx_tail = 0;
    check_head(1, 4);
    do_dispose();
    check_head(2, 4);
    chk("R8 ready again", rx_ready, 1);
    do_dispose();

    // R8 message count full
    for (int k = 0; k < 4; k++) rx_send(10 + k, 1);
    chk("R8 messages full", rx_ready, 0);
    for (int k = 0; k < 4; k++) begin
      check_head(10 + k, 1);
      do_dispose();
    end

    // R7 dispose while empty
    chk("R7 err clear", disp_err, 0);
    do_dispose();
    chk("R7 err set", disp_err, 1);
    chk("R7 still empty", rx_present, 0);
    rx_send(20, 3);
    check_head(20, 3);
    err_clr = 1; step(); err_clr = 0;
    chk("R10 disp_err cleared", disp_err, 0);
    chk("R10 queue intact", rx_present, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule